// File: doc/BRIEF.md
# Random Bit Generator Register Peripheral

This block is a memory-mapped random bit generator on a simple 32-bit register bus. Six oscillator lines, supplied either from an input port or from an internal LFSR stand-in, are reduced by two combiners. Each combiner XORs the lines that its 6-bit control field leaves enabled. A bit clock moves combiner bits into a 32-bit shift register. The bit clock is the entropy strobe, every bus clock, or a divided bus clock. Full words go into a small FIFO that software drains through a data register.

Before turning the generator on, software loads a warm-up count through the status register. Each generated bit is thrown away and decrements the count until it reaches zero. The status register also reports how many words wait in the FIFO. An interrupt request signals that the FIFO has reached a programmable threshold. The request can be masked.

Top module: `rbg_periph`

## Requirements
- R1: After reset, control reads 0x0000_0000, status reads 0x0000_0000, threshold reads 0x0000_0010, interrupt mask reads 0x0000_0000 and irq is low.
- R2: Registers sit at byte offsets control 0x00, status 0x04, data 0x08, threshold 0x0C and mask 0x10. Read data appears on bus_rdata the cycle after the read strobe. Control keeps only bits 27:8, 5:4 and 1:0. Threshold keeps bits 4:0. Mask keeps bit 0. Every other bit reads as 0.
- R3: Writing status loads bits 19:0 into the warm-up count and ignores bits 31:20. Each generated bit decrements a nonzero count and is discarded. Only bits generated once the count is zero reach the FIFO.
- R4: After warm-up, each group of 32 kept bits becomes one FIFO word. The first bit of the group lands in bit 31 and the last in bit 0.
- R5: Combiner A XORs the ent_osc lines whose bit is 0 in control 21:16. Combiner B does the same with control 27:22. With control bit 1 clear, each bit-clock tick yields one bit from A. With it set, each tick yields A's bit and then B's bit.
- R6: With control bit 4 clear, a tick occurs on each cycle ent_strobe is high. With bit 4 set and bit 5 clear, a tick occurs every bus clock. With both set, a tick occurs every 2*(N+1) bus clocks, where N is control 15:8.
- R7: With control bit 0 clear, no bits are generated. The FIFO contents, the warm-up count and the partly filled word are all kept.
- R8: Status bits 31:24 give the FIFO word count. Each data read returns the oldest word and removes it. A data read on an empty FIFO returns 0 and leaves the count at 0.
- R9: The FIFO holds 16 words. A word completed while the FIFO is full is dropped, and the stored words are kept.
- R10: irq is high exactly when mask bit 0 is clear and the FIFO word count is at or above the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ent_osc | input | 6 | Oscillator lines feeding both combiners |
| ent_strobe | input | 1 | Bit clock used when the jitter bypass is off |
| irq | output | 1 | FIFO-level interrupt request |

## Verification
The bench targets the cases where the bit count goes wrong. A warm-up count that is partly used up must still discard its remaining bits. If the decrement were missing, or keeping started too early, the following word would come out shifted. In divided and double-speed modes, the warm-up counter is used to count ticks. An off-by-one divider, or a double-speed path that consumes only one bit per tick, leaves the wrong residue. Strobes sent while the generator is disabled must not reach the half-built word, or the next word will not match. The bench also checks that a seventeenth word is dropped and does not overwrite data. It checks that an empty read returns zero and does not wrap the count. Finally, it checks that a zero threshold raises irq even when the FIFO is empty.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
    localparam int OSC_W    = 6;
    localparam int WARM_W   = 20;
    localparam int LVL_W    = 8;
    localparam int THR_W    = 5;
    localparam int DIV_W    = 8;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_DATA = 'h08;
    localparam int OFF_THR  = 'h0C;
    localparam int OFF_MASK = 'h10;

    typedef struct packed {
        logic [OSC_W-1:0] osc_b;
        logic [OSC_W-1:0] osc_a;
        logic [DIV_W-1:0] div_n;
        logic             src_div;
        logic             byp;
        logic             dbl;
        logic             en;
    } ctrl_t;

    function automatic logic [31:0] ctrl_pack(ctrl_t c);
        return {4'b0, c.osc_b, c.osc_a, c.div_n, 2'b0, c.src_div, c.byp,
                2'b0, c.dbl, c.en};
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [31:0] w);
        ctrl_t c;
        c.osc_b   = w[27:22];
        c.osc_a   = w[21:16];
        c.div_n   = w[15:8];
        c.src_div = w[5];
        c.byp     = w[4];
        c.dbl     = w[1];
        c.en      = w[0];
        return c;
    endfunction
endpackage

// File: rtl/rbg_entropy_src.sv
module rbg_entropy_src #(
    parameter int N_OSC   = 6,
    parameter bit EXT_SRC = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OSC-1:0] ent_osc,
    input  logic             ent_strobe,
    input  logic [N_OSC-1:0] off_a,
    input  logic [N_OSC-1:0] off_b,
    output logic             bit_a,
    output logic             bit_b,
    output logic             stb
);
    typedef struct packed {
        logic a;
        logic b;
        logic s;
    } src_state_t;

    src_state_t s_d, s_q;
    logic [N_OSC-1:0] lines;
    logic             raw_stb;

    generate
        if (EXT_SRC) begin : g_ext
            assign lines   = ent_osc;
            assign raw_stb = ent_strobe;
        end else begin : g_lfsr
            logic [15:0] lfsr_d, lfsr_q;
            always_comb begin
                lfsr_d = {lfsr_q[14:0],
                          lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lfsr_q <= 16'hACE1;
                else        lfsr_q <= lfsr_d;
            end
            assign lines   = lfsr_q[N_OSC-1:0];
            assign raw_stb = 1'b1;
        end
    endgenerate

    always_comb begin
        s_d.a = ^(lines & ~off_a);
        s_d.b = ^(lines & ~off_b);
        s_d.s = raw_stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_a = s_q.a;
    assign bit_b = s_q.b;
    assign stb   = s_q.s;
endmodule

// File: rtl/rbg_tick_gen.sv
module rbg_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             byp,
    input  logic             src_div,
    input  logic [DIV_W-1:0] div_n,
    input  logic             stb,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t      s_d, s_q;
    logic [CNT_W-1:0] limit;
    logic             div_hit;
    logic             div_mode;

    always_comb begin
        limit    = {div_n, 1'b1};
        div_hit  = (s_q.cnt == limit);
        div_mode = en && byp && src_div;
        s_d      = s_q;
        if (!div_mode || div_hit) s_d.cnt = '0;
        else                      s_d.cnt = s_q.cnt + 1'b1;
        if (!en)      tick = 1'b0;
        else if (byp) tick = src_div ? div_hit : 1'b1;
        else          tick = stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: divided ticks are never on consecutive cycles
    p_div_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_mode) |=> !(tick && div_mode));
endmodule

// File: rtl/rbg_packer.sv
module rbg_packer #(
    parameter int WORD_W = 32,
    parameter int WARM_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              dbl,
    input  logic              bit_a,
    input  logic              bit_b,
    input  logic              warm_load,
    input  logic [WARM_W-1:0] warm_val,
    output logic [WARM_W-1:0] warm,
    output logic              push,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W) + 1;

    typedef struct packed {
        logic [WARM_W-1:0] warm;
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              push;
        logic [WORD_W-1:0] word;
    } pack_state_t;

    pack_state_t s_d, s_q;
    logic        nb;

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;
        nb       = 1'b0;
        if (tick) begin
            for (int i = 0; i < 2; i++) begin
                if (i == 0 || dbl) begin
                    nb = (i == 0) ? bit_a : bit_b;
                    if (s_d.warm != '0) begin
                        s_d.warm = s_d.warm - 1'b1;
                    end else begin
                        s_d.sh  = {s_d.sh[WORD_W-2:0], nb};
                        s_d.cnt = s_d.cnt + 1'b1;
                        if (s_d.cnt == CNT_W'(WORD_W)) begin
                            s_d.push = 1'b1;
                            s_d.word = s_d.sh;
                            s_d.cnt  = '0;
                        end
                    end
                end
            end
        end
        if (warm_load) s_d.warm = warm_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign warm = s_q.warm;
    assign push = s_q.push;
    assign word = s_q.word;

    // R3: with more than one bit of warm-up left, nothing can be kept
    p_warm_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.warm > WARM_W'(1)) |=> !push);
endmodule

// File: rtl/rbg_fifo.sv
module rbg_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [LVL_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic        do_pop, do_push;

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && ((s_q.cnt != LVL_W'(DEPTH)) || do_pop);
        if (do_pop) s_d.rd = nxt(s_q.rd);
        if (do_push) begin
            s_d.mem[s_q.wr] = wdata;
            s_d.wr          = nxt(s_q.wr);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rd];
    assign level = s_q.cnt;

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH) && push && !pop) |=> level == LVL_W'(DEPTH));
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && pop && !push) |=> level == '0);
endmodule

// File: rtl/rbg_periph.sv
module rbg_periph #(
    parameter int   ADDR_W     = 5,
    parameter int   FIFO_DEPTH = 16,
    parameter bit   EXT_SRC    = 1'b1,
    parameter logic [4:0] THR_RST = 5'h10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_en,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [rbg_pkg::OSC_W-1:0] ent_osc,
    input  logic                     ent_strobe,
    output logic                     irq
);
    import rbg_pkg::*;

    localparam int WORD_W = 32;
    localparam int FL_W   = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [THR_W-1:0] thr;
        logic             irq_off;
        logic [31:0]      rdata;
    } reg_state_t;

    reg_state_t s_d, s_q;

    logic              wr_acc, rd_acc, pop, warm_load, tick;
    logic              bit_a, bit_b, stb, push;
    logic [WARM_W-1:0] warm;
    logic [WORD_W-1:0] word, head;
    logic [FL_W-1:0]   level;
    logic [LVL_W-1:0]  level8;

    assign wr_acc    = bus_en && bus_we;
    assign rd_acc    = bus_en && !bus_we;
    assign pop       = rd_acc && (bus_addr == ADDR_W'(OFF_DATA));
    assign warm_load = wr_acc && (bus_addr == ADDR_W'(OFF_STAT));
    assign level8    = LVL_W'(level);

    rbg_entropy_src #(.N_OSC(OSC_W), .EXT_SRC(EXT_SRC)) u_src (
        .clk(clk), .rst_n(rst_n), .ent_osc(ent_osc), .ent_strobe(ent_strobe),
        .off_a(s_q.ctrl.osc_a), .off_b(s_q.ctrl.osc_b),
        .bit_a(bit_a), .bit_b(bit_b), .stb(stb));

    rbg_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(s_q.ctrl.en), .byp(s_q.ctrl.byp),
        .src_div(s_q.ctrl.src_div), .div_n(s_q.ctrl.div_n), .stb(stb),
        .tick(tick));

    rbg_packer #(.WORD_W(WORD_W), .WARM_W(WARM_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(s_q.ctrl.dbl),
        .bit_a(bit_a), .bit_b(bit_b), .warm_load(warm_load),
        .warm_val(bus_wdata[WARM_W-1:0]), .warm(warm), .push(push),
        .word(word));

    rbg_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(word), .pop(pop),
        .head(head), .level(level));

    always_comb begin
        s_d = s_q;
        if (wr_acc) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) s_d.ctrl    = ctrl_unpack(bus_wdata);
            if (bus_addr == ADDR_W'(OFF_THR))  s_d.thr     = bus_wdata[THR_W-1:0];
            if (bus_addr == ADDR_W'(OFF_MASK)) s_d.irq_off = bus_wdata[0];
        end
        if (rd_acc) begin
            s_d.rdata = '0;
            if (bus_addr == ADDR_W'(OFF_CTRL)) s_d.rdata = ctrl_pack(s_q.ctrl);
            if (bus_addr == ADDR_W'(OFF_STAT)) s_d.rdata = {level8, 4'b0, warm};
            if (bus_addr == ADDR_W'(OFF_DATA)) s_d.rdata = (level != '0) ? head : '0;
            if (bus_addr == ADDR_W'(OFF_THR))  s_d.rdata = 32'(s_q.thr);
            if (bus_addr == ADDR_W'(OFF_MASK)) s_d.rdata = 32'(s_q.irq_off);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.thr     <= THR_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign irq       = !s_q.irq_off && (level8 >= LVL_W'(s_q.thr));

    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq_off |-> !irq);
    p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.en && !$past(s_q.ctrl.en) && !pop) |=> $stable(level));
endmodule

// File: tb/rbg_periph_tb_top.sv
module rbg_periph_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  ent_osc = '0;
    logic        ent_strobe = 1'b0;
    logic        irq;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    rbg_periph dut_i (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_osc(ent_osc), .ent_strobe(ent_strobe), .irq(irq));

    // {dbl, field_a, field_b, word}
    localparam logic [44:0] VEC [6] = '{
        {1'b0, 6'b111110, 6'b000000, 32'hA5C3_0F71},
        {1'b0, 6'b000000, 6'b000000, 32'h1234_5678},
        {1'b0, 6'b101010, 6'b000000, 32'hFFFF_0000},
        {1'b1, 6'b111100, 6'b110011, 32'hDEAD_BEEF},
        {1'b1, 6'b011111, 6'b111110, 32'h0000_0001},
        {1'b0, 6'b111101, 6'b000000, 32'h8000_0000}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [5:0] osc_for(bit dbl, logic [5:0] fa, logic [5:0] fb,
                                           bit ca, bit cb);
        logic [5:0] ea, eb, o;
        ea = ~fa; eb = ~fb;
        o  = dbl ? ~(ea | eb) : ~ea;
        if (ca)        o = o | (ea & (~ea + 6'd1));
        if (dbl && cb) o = o | (eb & (~eb + 6'd1));
        return o;
    endfunction

    task automatic drive_word(bit dbl, logic [5:0] fa, logic [5:0] fb, logic [31:0] w);
        int nstb;
        nstb = dbl ? 16 : 32;
        for (int k = 0; k < nstb; k++) begin
            @(negedge clk);
            ent_strobe = 1'b1;
            if (dbl) ent_osc = osc_for(1'b1, fa, fb, w[31-2*k], w[30-2*k]);
            else     ent_osc = osc_for(1'b0, fa, fb, w[31-k], 1'b0);
        end
        @(negedge clk);
        ent_strobe = 1'b0; ent_osc = '0;
        idle(5);
    endtask

    task automatic drive_bits(int n, logic [5:0] o);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ent_strobe = 1'b1; ent_osc = o;
        end
        @(negedge clk);
        ent_strobe = 1'b0; ent_osc = '0;
        idle(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset values
        bus_rd(5'h00, rd); check("R1 ctrl", rd, 32'h0);
        bus_rd(5'h04, rd); check("R1 status", rd, 32'h0);
        bus_rd(5'h0C, rd); check("R1 thr", rd, 32'h10);
        bus_rd(5'h10, rd); check("R1 mask", rd, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 writable bits and readback
        bus_wr(5'h00, 32'hFFFF_FFFE);
        bus_rd(5'h00, rd); check("R2 ctrl bits", rd, 32'h0FFF_FF32);
        bus_wr(5'h0C, 32'hFFFF_FFFF);
        bus_rd(5'h0C, rd); check("R2 thr bits", rd, 32'h1F);
        bus_wr(5'h10, 32'hFFFF_FFFF);
        bus_rd(5'h10, rd); check("R2 mask bits", rd, 32'h1);
        bus_wr(5'h00, 32'h0); bus_wr(5'h0C, 32'h10); bus_wr(5'h10, 32'h0);
        // R8 empty read
        bus_rd(5'h08, rd); check("R8 empty data", rd, 32'h0);
        bus_rd(5'h04, rd); check("R8 empty count", rd, 32'h0);

        // R4 R5 vector table
        for (int v = 0; v < 6; v++) begin
            bus_wr(5'h00, {4'b0, VEC[v][37:32], VEC[v][43:38], 8'h0, 6'b0,
                           VEC[v][44], 1'b1});
            drive_word(VEC[v][44], VEC[v][43:38], VEC[v][37:32], VEC[v][31:0]);
            bus_rd(5'h04, rd); check("R8 count one", rd, 32'h0100_0000);
            bus_rd(5'h08, rd); check("R4 R5 word", rd, VEC[v][31:0]);
            bus_rd(5'h04, rd); check("R8 count zero", rd, 32'h0);
        end
        bus_wr(5'h00, 32'h0);

        // R3 warm-up discard
        bus_wr(5'h04, 32'hFFF0_0005);
        bus_rd(5'h04, rd); check("R3 load", rd, 32'h5);
        bus_wr(5'h00, 32'h003E_0001);
        drive_bits(3, 6'h3F);
        bus_rd(5'h04, rd); check("R3 partial", rd, 32'h2);
        drive_bits(2, 6'h3F);
        drive_word(1'b0, 6'b111110, 6'h0, 32'h0F0F_3C3C);
        bus_rd(5'h04, rd); check("R3 count", rd, 32'h0100_0000);
        bus_rd(5'h08, rd); check("R3 word", rd, 32'h0F0F_3C3C);
        bus_wr(5'h00, 32'h0);

        // R6 tick sources, counted through the warm-up counter
        bus_wr(5'h04, 32'd1000);
        bus_wr(5'h00, 32'h0000_0231); idle(60); bus_wr(5'h00, 32'h0);
        bus_rd(5'h04, rd); check("R6 divided N=2", rd, 32'd990);
        bus_wr(5'h04, 32'd1000);
        bus_wr(5'h00, 32'h0000_0011); idle(18); bus_wr(5'h00, 32'h0);
        bus_rd(5'h04, rd); check("R6 undivided", rd, 32'd980);
        bus_wr(5'h04, 32'd1000);
        bus_wr(5'h00, 32'h0000_0013); idle(18); bus_wr(5'h00, 32'h0);
        bus_rd(5'h04, rd); check("R5 R6 double speed", rd, 32'd960);
        bus_wr(5'h04, 32'd1000);
        bus_wr(5'h00, 32'h0000_0001); idle(18); bus_wr(5'h00, 32'h0);
        bus_rd(5'h04, rd); check("R6 strobe idle", rd, 32'd1000);
        bus_wr(5'h04, 32'h0);

        // R7 disable keeps FIFO and partial word
        bus_wr(5'h00, 32'h003E_0001);
        drive_word(1'b0, 6'b111110, 6'h0, 32'hC001_D00D);
        bus_wr(5'h00, 32'h003E_0000);
        drive_bits(32, 6'h3F);
        bus_rd(5'h04, rd); check("R7 count kept", rd, 32'h0100_0000);
        bus_rd(5'h08, rd); check("R7 word kept", rd, 32'hC001_D00D);
        bus_wr(5'h00, 32'h003E_0001);
        drive_word(1'b0, 6'b111110, 6'h0, 32'h1357_9BDF);
        bus_rd(5'h08, rd); check("R7 no stray bits", rd, 32'h1357_9BDF);
        bus_rd(5'h04, rd); check("R7 count after", rd, 32'h0);

        // R10 irq
        bus_wr(5'h0C, 32'h2);
        drive_word(1'b0, 6'b111110, 6'h0, 32'h0000_00AA);
        check("R10 below thr", 32'(irq), 32'h0);
        drive_word(1'b0, 6'b111110, 6'h0, 32'h0000_0055);
        check("R10 at thr", 32'(irq), 32'h1);
        bus_wr(5'h10, 32'h1); idle(1);
        check("R10 masked", 32'(irq), 32'h0);
        bus_wr(5'h10, 32'h0); idle(1);
        check("R10 unmasked", 32'(irq), 32'h1);
        bus_rd(5'h08, rd); idle(1);
        check("R10 after pop", 32'(irq), 32'h0);
        bus_wr(5'h0C, 32'h0); idle(1);
        check("R10 thr zero", 32'(irq), 32'h1);
        bus_rd(5'h08, rd); idle(1);
        check("R10 thr zero empty", 32'(irq), 32'h1);
        bus_wr(5'h0C, 32'h10); idle(1);
        check("R10 restored", 32'(irq), 32'h0);

        // R9 full FIFO drops the extra word
        for (int i = 0; i < 17; i++)
            drive_word(1'b0, 6'b111110, 6'h0,
                       {8'(i), 8'(~i), 8'(i * 3), 8'hA5});
        bus_rd(5'h04, rd); check("R9 count full", rd, 32'h1000_0000);
        check("R10 full irq", 32'(irq), 32'h1);
        for (int i = 0; i < 16; i++) begin
            bus_rd(5'h08, rd);
            check("R9 order", rd, {8'(i), 8'(~i), 8'(i * 3), 8'hA5});
        end
        bus_rd(5'h08, rd); check("R9 R8 dropped word", rd, 32'h0);
        bus_rd(5'h04, rd); check("R9 count drained", rd, 32'h0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule